// File: doc/BRIEF.md
# Optical-Black Dark Level Compensator

This block removes the sensor's dark offset from a raw 10-bit pixel stream. While the shielded (optical-black) rows at the top of a frame stream past, it collects a fixed 1024-pixel sample and takes the floor mean. Once that sample is complete, the mean enters a first-order recursive filter: each update adds a scaled sum of the new mean and the previous mean to a scaled copy of the previous filter state. The state is rounded to an integer dark level. That level, moved by a signed user offset, is subtracted from every active pixel that follows, and the result is clamped to the pixel range.

The filter does not have to run on every frame. Four enable controls let it run on every frame, on the frame after a gain change or a shutter change, or on a short burst of one to four frames. In a frame where the filter does not run, the last level is kept and still applied. With all four controls low, the block does no dark level correction: the 8-bit offset then becomes a plain unsigned amount subtracted from each pixel.

Top module: `dark_level_comp`

## Requirements
- R1: After reset `pix_out` is 0 and `pix_out_valid` is 0. For each cycle with `act_valid` high, `pix_out_valid` is high in the following cycle with the corrected pixel, and it is low after every cycle with `act_valid` low.
- R2: Sampling area: with `area_wide`=0, the first 128 pixels of each of the first 8 runs of `ob_valid` in a frame are summed. With `area_wide`=1, the first 512 pixels of each of the first 2 runs are summed. Pixels past these limits are ignored. The measured mean is the 1024-pixel sum shifted right by 10.
- R3: The filter state D keeps 4 fractional bits. The A term is 16·(M + P) shifted right by 0-term/1/2/3 for `coef_a` codes 00/01/10/11, which means gain 0, 0.5, 0.25 and 0.125. M is the new mean and P is the previous mean.
- R4: The B term for `coef_b` codes 00/01/10/11 is 0, D>>1, (D>>1)+(D>>2) and D, which means gain 0, 0.5, 0.75 and 1. The new D is the sum of the A and B terms, capped at 16383.
- R5: With `ob_self`=1, P is replaced by the current mean M. After every update the stored previous mean becomes M.
- R6: D changes only in a frame that is armed and that collects all 1024 samples. Otherwise the last level is held and still applied.
- R7: `en_always` arms every frame. `en_gain` arms a frame if `gain_evt` pulsed since the last `frame_start`, and `en_shutter` does the same with `shut_evt`. Both pending events clear at every `frame_start`.
- R8: With `en_count` high, the `count_len`+1 frames that start after it is raised are armed, and later frames are not. The count reloads while `en_count` is low.
- R9: Applied level = (D + 8) >> 4, capped at 1023. D and the previous mean reset to 0.
- R10: With any enable high: out = clamp(pix − level ± mag, 0, 1023). Here mag = `offset`[6:0]; it is added when `offset`[7]=1 and subtracted when `offset`[7]=0.
- R11: With all enables low: out = max(pix − `offset`[7:0], 0), and the dark level does not apply.
- R12: A new level applies to active pixels presented two cycles or more after the last accepted dark sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse that opens a frame |
| ob_valid | input | 1 | Current pixel is optical-black |
| act_valid | input | 1 | Current pixel is active image data |
| pix_in | input | 10 | Raw pixel value |
| gain_evt | input | 1 | Pulse: analog gain was changed |
| shut_evt | input | 1 | Pulse: exposure was changed |
| en_always | input | 1 | Filter runs every frame |
| en_gain | input | 1 | Filter runs after a gain change |
| en_shutter | input | 1 | Filter runs after a shutter change |
| en_count | input | 1 | Filter runs for a limited number of frames |
| count_len | input | 2 | Frame count minus one for limited mode |
| coef_a | input | 2 | Measurement gain code |
| coef_b | input | 2 | State feedback gain code |
| ob_self | input | 1 | Use current mean in place of previous |
| area_wide | input | 1 | 0: 128x8 sample area, 1: 512x2 |
| offset | input | 8 | User offset (sign-magnitude or unsigned) |
| pix_out | output | 10 | Corrected pixel |
| pix_out_valid | output | 1 | Corrected pixel valid |

## Verification
The assertions assume that `ob_valid` and `act_valid` are never high together, that `frame_start` comes while neither is high, and that every frame places its dark rows before its active pixels. The stimulus keeps to this. Each frame opens with a lone start pulse, then separates its dark rows by idle cycles, and only then streams active pixels, with random gaps. Control fields and event pulses change only between frames, and `count_len` settles before `en_count` is raised. This keeps the arming decision well defined.

// File: rtl/dlc_pkg.sv
// Shared coefficient encodings for the dark level compensator.
package dlc_pkg;
    typedef enum logic [1:0] {
        CA_ZERO    = 2'b00,
        CA_HALF    = 2'b01,
        CA_QUARTER = 2'b10,
        CA_EIGHTH  = 2'b11
    } coef_a_e;

    typedef enum logic [1:0] {
        CB_ZERO   = 2'b00,
        CB_HALF   = 2'b01,
        CB_THREEQ = 2'b10,
        CB_ONE    = 2'b11
    } coef_b_e;
endpackage

// File: rtl/dlc_ob_meter.sv
// Dark sample meter.
// Sums a fixed-size block of optical-black pixels per frame. A row is a
// contiguous run of ob_valid. Only the first COLS pixels of the first ROWS
// runs count, with the geometry chosen by area_wide.
// Assumes: both geometries hold the same power-of-two pixel count, and
// frame_start never coincides with ob_valid.
module dlc_ob_meter #(
    parameter int PIX_W     = 10,
    parameter int NAR_COLS  = 128,
    parameter int NAR_ROWS  = 8,
    parameter int WIDE_COLS = 512,
    parameter int WIDE_ROWS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             ob_valid,
    input  logic [PIX_W-1:0] pix_in,
    input  logic             area_wide,
    output logic             meas_done,
    output logic [PIX_W-1:0] ob_mean
);
    localparam int AREA     = NAR_COLS * NAR_ROWS;
    localparam int LOG2     = $clog2(AREA);
    localparam int SUM_W    = PIX_W + LOG2;
    localparam int CNT_W    = LOG2 + 1;
    localparam int MAX_COLS = (NAR_COLS > WIDE_COLS) ? NAR_COLS : WIDE_COLS;
    localparam int MAX_ROWS = (NAR_ROWS > WIDE_ROWS) ? NAR_ROWS : WIDE_ROWS;
    localparam int COL_W    = $clog2(MAX_COLS + 1);
    localparam int ROW_W    = $clog2(MAX_ROWS + 1);

    logic [COL_W-1:0] col_q;
    logic [ROW_W-1:0] row_q;
    logic [CNT_W-1:0] taken_q;
    logic [SUM_W-1:0] sum_q;
    logic             run_q;
    logic             done_q;
    logic [COL_W-1:0] col_lim;
    logic [ROW_W-1:0] row_lim;
    logic             accept;

    // Pick the sampling window geometry.
    always_comb begin
        col_lim = area_wide ? COL_W'(WIDE_COLS) : COL_W'(NAR_COLS);
        row_lim = area_wide ? ROW_W'(WIDE_ROWS) : ROW_W'(NAR_ROWS);
    end

    // A pixel counts when it falls inside the window and the block is not full.
    assign accept = ob_valid && (row_q < row_lim) && (col_q < col_lim)
                    && (taken_q < CNT_W'(AREA));

    // Track row/column position and accumulate accepted samples.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_start) begin
            col_q   <= '0;
            row_q   <= '0;
            taken_q <= '0;
            sum_q   <= '0;
            run_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= accept && (taken_q == CNT_W'(AREA - 1));
            if (accept) begin
                sum_q   <= sum_q + SUM_W'(pix_in);
                taken_q <= taken_q + 1'b1;
            end
            if (ob_valid) begin
                run_q <= 1'b1;
                if (col_q < col_lim) col_q <= col_q + 1'b1;
            end else if (run_q) begin
                run_q <= 1'b0;
                col_q <= '0;
                if (row_q < row_lim) row_q <= row_q + 1'b1;
            end
        end
    end

    assign meas_done = done_q;
    assign ob_mean   = sum_q[SUM_W-1:LOG2];
endmodule

// File: rtl/dlc_enable_ctl.sv
// Frame arming control.
// Decides at each frame_start whether the filter may update during that
// frame. Gain and shutter events are latched until the next frame_start.
// The limited mode counts down frames from count_len+1.
// Assumes: count_len is stable before en_count is raised.
module dlc_enable_ctl #(
    parameter int LEN_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             gain_evt,
    input  logic             shut_evt,
    input  logic             en_always,
    input  logic             en_gain,
    input  logic             en_shutter,
    input  logic             en_count,
    input  logic [LEN_W-1:0] count_len,
    output logic             arm
);
    localparam int LEFT_W = LEN_W + 1;

    logic              arm_q;
    logic              gain_pend_q;
    logic              shut_pend_q;
    logic [LEFT_W-1:0] left_q;
    logic              count_live;

    assign count_live = en_count && (left_q != '0);

    // Latch events, make the per-frame decision and run the frame budget.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q       <= 1'b0;
            gain_pend_q <= 1'b0;
            shut_pend_q <= 1'b0;
            left_q      <= '0;
        end else begin
            if (frame_start) begin
                arm_q <= en_always
                       | (en_gain    & (gain_pend_q | gain_evt))
                       | (en_shutter & (shut_pend_q | shut_evt))
                       | count_live;
                gain_pend_q <= 1'b0;
                shut_pend_q <= 1'b0;
                if (count_live) left_q <= left_q - 1'b1;
            end else begin
                gain_pend_q <= gain_pend_q | gain_evt;
                shut_pend_q <= shut_pend_q | shut_evt;
            end
            if (!en_count) left_q <= LEFT_W'(count_len) + 1'b1;
        end
    end

    assign arm = arm_q;
endmodule

// File: rtl/dlc_filter.sv
// Recursive dark level filter.
// Per update: D = A*(M + P) + B*D in fixed point with FRAC fractional bits,
// saturated to the integer pixel range. Emits the rounded integer level.
// Assumes: FRAC >= 3 so the smallest A gain is exact.
module dlc_filter
    import dlc_pkg::*;
#(
    parameter int PIX_W = 10,
    parameter int FRAC  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             meas_done,
    input  logic [PIX_W-1:0] ob_mean,
    input  logic [1:0]       coef_a,
    input  logic [1:0]       coef_b,
    input  logic             ob_self,
    output logic [PIX_W-1:0] level
);
    localparam int D_W   = PIX_W + FRAC;
    localparam int SUM_W = D_W + 2;
    localparam logic [SUM_W-1:0] D_MAX = SUM_W'((1 << D_W) - 1);
    localparam logic [D_W:0]     HALF  = (D_W + 1)'(1 << (FRAC - 1));

    logic [D_W-1:0]   d_q;
    logic [PIX_W-1:0] prev_q;
    logic [PIX_W-1:0] level_q;
    logic [PIX_W-1:0] partner;
    logic [PIX_W:0]   pair;
    logic [SUM_W-1:0] pair_fx;
    logic [SUM_W-1:0] d_ext;
    logic [SUM_W-1:0] term_a;
    logic [SUM_W-1:0] term_b;
    logic [SUM_W-1:0] total;
    logic [D_W-1:0]   d_next;
    logic [D_W:0]     rnd;
    logic [PIX_W-1:0] lvl_next;

    // Form the measurement term from the chosen pair of means.
    always_comb begin
        partner = ob_self ? ob_mean : prev_q;
        pair    = {1'b0, ob_mean} + {1'b0, partner};
        pair_fx = SUM_W'({pair, {FRAC{1'b0}}});
        case (coef_a_e'(coef_a))
            CA_ZERO:    term_a = '0;
            CA_HALF:    term_a = pair_fx >> 1;
            CA_QUARTER: term_a = pair_fx >> 2;
            default:    term_a = pair_fx >> 3;
        endcase
    end

    // Form the feedback term from the stored state.
    always_comb begin
        d_ext = SUM_W'(d_q);
        case (coef_b_e'(coef_b))
            CB_ZERO:   term_b = '0;
            CB_HALF:   term_b = d_ext >> 1;
            CB_THREEQ: term_b = (d_ext >> 1) + (d_ext >> 2);
            default:   term_b = d_ext;
        endcase
    end

    // Saturate the new state and round it to an integer level.
    always_comb begin
        total    = term_a + term_b;
        d_next   = (total > D_MAX) ? D_MAX[D_W-1:0] : total[D_W-1:0];
        rnd      = {1'b0, d_next} + HALF;
        lvl_next = rnd[D_W] ? {PIX_W{1'b1}} : rnd[D_W-1:FRAC];
    end

    // Commit state only on an armed, completed measurement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_q     <= '0;
            prev_q  <= '0;
            level_q <= '0;
        end else if (arm && meas_done) begin
            d_q     <= d_next;
            prev_q  <= ob_mean;
            level_q <= lvl_next;
        end
    end

    assign level = level_q;
endmodule

// File: rtl/dlc_correct.sv
// Pixel corrector.
// Registers each active pixel after subtracting the dark level with a
// sign-magnitude offset (compensation on), or an unsigned offset alone
// (compensation off), then clamps to the pixel range.
// Assumes: OFF_W <= PIX_W + 2.
module dlc_correct #(
    parameter int PIX_W = 10,
    parameter int OFF_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_valid,
    input  logic [PIX_W-1:0] pix_in,
    input  logic [PIX_W-1:0] level,
    input  logic             comp_on,
    input  logic [OFF_W-1:0] offset,
    output logic [PIX_W-1:0] pix_out,
    output logic             out_valid
);
    localparam int MAG_W = OFF_W - 1;
    localparam int W     = PIX_W + 2;
    localparam logic signed [W-1:0] TOP_S = W'((1 << PIX_W) - 1);

    logic signed [W-1:0] pix_s;
    logic signed [W-1:0] lvl_s;
    logic signed [W-1:0] mag_s;
    logic signed [W-1:0] full_s;
    logic signed [W-1:0] adj;
    logic [PIX_W-1:0]    clipped;

    // Compute the corrected value in signed arithmetic and clamp it.
    always_comb begin
        pix_s  = $signed({2'b00, pix_in});
        lvl_s  = $signed({2'b00, level});
        mag_s  = $signed({{(W - MAG_W){1'b0}}, offset[MAG_W-1:0]});
        full_s = $signed({{(W - OFF_W){1'b0}}, offset});
        if (comp_on)
            adj = pix_s - lvl_s + (offset[OFF_W-1] ? mag_s : -mag_s);
        else
            adj = pix_s - full_s;
        if (adj < 0)
            clipped = '0;
        else if (adj > TOP_S)
            clipped = {PIX_W{1'b1}};
        else
            clipped = adj[PIX_W-1:0];
    end

    // Output register, one cycle behind the input pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_out   <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= act_valid;
            if (act_valid) pix_out <= clipped;
        end
    end
endmodule

// File: rtl/dark_level_comp.sv
// Dark level compensator top.
// Ties the dark sample meter, frame arming control, recursive filter and
// pixel corrector together. Compensation is on when any enable is high.
// Assumes: dark rows precede active pixels in a frame and the two flags are
// never high together.
module dark_level_comp #(
    parameter int PIX_W     = 10,
    parameter int FRAC_BITS = 4,
    parameter int OFF_W     = 8,
    parameter int LEN_W     = 2,
    parameter int NAR_COLS  = 128,
    parameter int NAR_ROWS  = 8,
    parameter int WIDE_COLS = 512,
    parameter int WIDE_ROWS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             ob_valid,
    input  logic             act_valid,
    input  logic [PIX_W-1:0] pix_in,
    input  logic             gain_evt,
    input  logic             shut_evt,
    input  logic             en_always,
    input  logic             en_gain,
    input  logic             en_shutter,
    input  logic             en_count,
    input  logic [LEN_W-1:0] count_len,
    input  logic [1:0]       coef_a,
    input  logic [1:0]       coef_b,
    input  logic             ob_self,
    input  logic             area_wide,
    input  logic [OFF_W-1:0] offset,
    output logic [PIX_W-1:0] pix_out,
    output logic             pix_out_valid
);
    logic             meas_done_w;
    logic [PIX_W-1:0] ob_mean_w;
    logic             arm_w;
    logic [PIX_W-1:0] level_w;
    logic             comp_on_w;

    assign comp_on_w = en_always | en_gain | en_shutter | en_count;

    dlc_ob_meter #(
        .PIX_W(PIX_W), .NAR_COLS(NAR_COLS), .NAR_ROWS(NAR_ROWS),
        .WIDE_COLS(WIDE_COLS), .WIDE_ROWS(WIDE_ROWS)
    ) u_meter (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .ob_valid(ob_valid), .pix_in(pix_in), .area_wide(area_wide),
        .meas_done(meas_done_w), .ob_mean(ob_mean_w)
    );

    dlc_enable_ctl #(.LEN_W(LEN_W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .gain_evt(gain_evt), .shut_evt(shut_evt),
        .en_always(en_always), .en_gain(en_gain),
        .en_shutter(en_shutter), .en_count(en_count),
        .count_len(count_len), .arm(arm_w)
    );

    dlc_filter #(.PIX_W(PIX_W), .FRAC(FRAC_BITS)) u_filter (
        .clk(clk), .rst_n(rst_n), .arm(arm_w), .meas_done(meas_done_w),
        .ob_mean(ob_mean_w), .coef_a(coef_a), .coef_b(coef_b),
        .ob_self(ob_self), .level(level_w)
    );

    dlc_correct #(.PIX_W(PIX_W), .OFF_W(OFF_W)) u_correct (
        .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .pix_in(pix_in),
        .level(level_w), .comp_on(comp_on_w), .offset(offset),
        .pix_out(pix_out), .out_valid(pix_out_valid)
    );
endmodule

// File: rtl/dlc_checker.sv
// Protocol and state checks for the dark level compensator, bound to the top.
module dlc_checker #(
    parameter int PIX_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_start,
    input logic             act_valid,
    input logic [PIX_W-1:0] pix_in,
    input logic [PIX_W-1:0] pix_out,
    input logic             pix_out_valid,
    input logic             en_always,
    input logic             en_gain,
    input logic             en_shutter,
    input logic             en_count,
    input logic             arm,
    input logic             meas_done,
    input logic [PIX_W-1:0] level
);
    AST_VALID_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid |=> pix_out_valid); // R1
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !act_valid |=> !pix_out_valid); // R1
    AST_DONE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        meas_done |=> !meas_done); // R2
    AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(arm && meas_done) |=> $stable(level)); // R6
    AST_ARM_ONLY_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(arm)); // R7
    AST_ALWAYS_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && en_always) |=> arm); // R7
    AST_PLAIN_NEVER_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (act_valid && !(en_always | en_gain | en_shutter | en_count))
        |=> (pix_out <= $past(pix_in))); // R11
endmodule

bind dark_level_comp dlc_checker #(.PIX_W(PIX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .act_valid(act_valid), .pix_in(pix_in), .pix_out(pix_out),
    .pix_out_valid(pix_out_valid), .en_always(en_always), .en_gain(en_gain),
    .en_shutter(en_shutter), .en_count(en_count), .arm(arm_w),
    .meas_done(meas_done_w), .level(level_w)
);

// File: tb/dark_level_comp_test.sv
// Self-checking bench: frames of random dark and active pixels under directed
// control settings, compared with a bench-side model of the requirements.
module dark_level_comp_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0, ob_valid = 1'b0, act_valid = 1'b0;
    logic [9:0] pix_in = '0;
    logic       gain_evt = 1'b0, shut_evt = 1'b0;
    logic       en_always = 1'b0, en_gain = 1'b0, en_shutter = 1'b0, en_count = 1'b0;
    logic [1:0] count_len = 2'd0, coef_a = 2'b10, coef_b = 2'b01;
    logic       ob_self = 1'b0, area_wide = 1'b0;
    logic [7:0] offset = 8'h00;
    logic [9:0] pix_out;
    logic       pix_out_valid;

    always #2 clk = ~clk;

    dark_level_comp uut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .ob_valid(ob_valid), .act_valid(act_valid), .pix_in(pix_in),
        .gain_evt(gain_evt), .shut_evt(shut_evt), .en_always(en_always),
        .en_gain(en_gain), .en_shutter(en_shutter), .en_count(en_count),
        .count_len(count_len), .coef_a(coef_a), .coef_b(coef_b),
        .ob_self(ob_self), .area_wide(area_wide), .offset(offset),
        .pix_out(pix_out), .pix_out_valid(pix_out_valid)
    );

    int    nvec = 0, nfail = 0;
    bit    finished = 1'b0;
    // Model state
    int    m_d = 0, m_prev = 0, m_level = 0, m_left = 1;
    bit    m_gpend = 1'b0, m_spend = 1'b0;
    // Pending output check
    bit    pend = 1'b0;
    int    pend_exp = 0;
    string pend_tag = "";

    task automatic chk(string tag, int act, int exp);
        nvec++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    endtask

    function automatic bit comp_on();
        return en_always | en_gain | en_shutter | en_count;
    endfunction

    // Expected corrected pixel (R10, R11).
    function automatic int ref_pix(int p);
        int v;
        if (comp_on()) v = p - m_level + (offset[7] ? int'(offset[6:0]) : -int'(offset[6:0]));
        else           v = p - int'(offset);
        if (v < 0) v = 0;
        if (v > 1023) v = 1023;
        return v;
    endfunction

    // One filter step (R3, R4).
    function automatic int filt_step(int mean, int partner, int d, int a, int b);
        int ta, tb, t;
        ta = (a == 0) ? 0 : (((mean + partner) * 16) >> a);
        case (b)
            0: tb = 0;
            1: tb = d >> 1;
            2: tb = (d >> 1) + (d >> 2);
            default: tb = d;
        endcase
        t = ta + tb;
        return (t > 16383) ? 16383 : t;
    endfunction

    // Rounded level (R9).
    function automatic int round_lvl(int d);
        int l;
        l = (d + 8) >> 4;
        return (l > 1023) ? 1023 : l;
    endfunction

    // Advance to the next falling edge and check the previous cycle's output.
    task automatic tick();
        @(negedge clk);
        if (pend) begin
            chk({pend_tag, " R1 valid"}, int'(pix_out_valid), 1);
            chk(pend_tag, int'(pix_out), pend_exp);
        end else begin
            chk("R1 idle valid", int'(pix_out_valid), 0);
        end
        pend = 1'b0;
    endtask

    task automatic pulse_gain();
        tick(); gain_evt = 1'b1; m_gpend = 1'b1;
        tick(); gain_evt = 1'b0;
    endtask

    task automatic pulse_shut();
        tick(); shut_evt = 1'b1; m_spend = 1'b1;
        tick(); shut_evt = 1'b0;
    endtask

    // One frame: start pulse, dark rows, then active pixels.
    task automatic run_frame(string tag, int rows, int rowlen, int base, int spread, int nact);
        int sum = 0, taken = 0, rlim, clim, mean;
        bit armed;
        string vtag;
        vtag = {tag, comp_on() ? "/R10" : "/R11"};
        rlim = area_wide ? 2 : 8;
        clim = area_wide ? 512 : 128;
        tick(); frame_start = 1'b1;
        armed = en_always | (en_gain & m_gpend) | (en_shutter & m_spend) | (en_count && m_left > 0);
        m_gpend = 1'b0; m_spend = 1'b0;
        if (en_count && m_left > 0) m_left--;
        tick(); frame_start = 1'b0;
        for (int r = 0; r < rows; r++) begin
            for (int c = 0; c < rowlen; c++) begin
                int v;
                tick();
                v = base + int'($urandom_range(spread, 0));
                if (v > 1023) v = 1023;
                ob_valid = 1'b1; pix_in = 10'(v);
                if (r < rlim && c < clim && taken < 1024) begin sum += v; taken++; end
            end
            tick(); ob_valid = 1'b0;
            if (r != rows - 1) tick();
        end
        // R6 / R12: update only when armed and complete; applies from 2 cycles on.
        if (armed && taken == 1024) begin
            mean    = sum >> 10;
            m_d     = filt_step(mean, ob_self ? mean : m_prev, m_d, int'(coef_a), int'(coef_b));
            m_prev  = mean;
            m_level = round_lvl(m_d);
        end
        for (int i = 0; i < nact; i++) begin
            int v;
            tick();
            if (i < 2 || $urandom_range(3, 0) != 0) begin
                v = (i == 0) ? 0 : (i == 1) ? 1023 : int'($urandom_range(1023, 0));
                act_valid = 1'b1; pix_in = 10'(v);
                pend = 1'b1; pend_exp = ref_pix(v); pend_tag = vtag;
            end else begin
                act_valid = 1'b0;
            end
        end
        tick(); act_valid = 1'b0;
        tick();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1 reset pix_out", int'(pix_out), 0);
        chk("R1 reset valid", int'(pix_out_valid), 0);
        rst_n = 1'b1;

        // R11: plain unsigned subtraction, no dark level.
        offset = 8'h30; run_frame("R11", 8, 130, 50, 10, 40);
        offset = 8'hFF; run_frame("R11", 8, 130, 50, 10, 40);

        // R3, R10, R12: always-on filtering, add then subtract offset.
        en_always = 1'b1; offset = 8'h85;
        run_frame("R12", 8, 128, 60, 15, 40);
        run_frame("R3", 8, 130, 60, 15, 40);
        run_frame("R3", 8, 130, 90, 15, 40);
        offset = 8'h05; run_frame("R10", 8, 130, 90, 15, 40);

        // R2: wide area with an extra row and overlong rows; narrow with extra rows.
        area_wide = 1'b1; run_frame("R2", 3, 520, 200, 30, 40);
        area_wide = 1'b0; run_frame("R2", 10, 140, 150, 30, 40);

        // R6: incomplete sample block leaves the level unchanged.
        run_frame("R6", 5, 130, 400, 20, 40);

        // R5: current mean used twice.
        ob_self = 1'b1; run_frame("R5", 8, 130, 300, 20, 40);
        ob_self = 1'b0; run_frame("R5", 8, 130, 100, 20, 40);

        // R3, R4: random coefficient codes.
        for (int k = 0; k < 6; k++) begin
            coef_a = 2'($urandom_range(3, 0));
            coef_b = 2'($urandom_range(3, 0));
            run_frame("R4", 8, 130, int'($urandom_range(300, 0)), 31, 30);
        end

        // R9: state saturates, level caps at 1023.
        coef_a = 2'b01; coef_b = 2'b11; offset = 8'hFF;
        run_frame("R9", 8, 130, 1000, 23, 30);
        run_frame("R9", 8, 130, 1000, 23, 30);
        run_frame("R9", 8, 130, 1000, 23, 30);

        // R7: gain-event mode holds without an event, runs after one.
        coef_a = 2'b10; coef_b = 2'b01; offset = 8'h00;
        en_always = 1'b0; en_gain = 1'b1;
        run_frame("R7", 8, 130, 100, 10, 40);
        pulse_gain();
        run_frame("R7", 8, 130, 120, 10, 40);
        run_frame("R7", 8, 130, 500, 10, 40);

        // R7: shutter-event mode.
        en_gain = 1'b0; en_shutter = 1'b1;
        pulse_shut();
        run_frame("R7", 8, 130, 500, 10, 40);
        run_frame("R7", 8, 130, 50, 10, 40);

        // R8: limited mode, count_len=1 gives two armed frames.
        en_shutter = 1'b0; count_len = 2'd1;
        tick(); tick();
        en_count = 1'b1; m_left = 2;
        run_frame("R8", 8, 130, 300, 10, 40);
        run_frame("R8", 8, 130, 600, 10, 40);
        run_frame("R8", 8, 130, 20, 10, 40);

        finished = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog R1 actual running expected finished");
            summary();
            $finish;
        end
    end
endmodule